// File: doc/BRIEF.md
# Lowest-Priority Interrupt Destination Router

This block decides which processor receives each interrupt request in a small multiprocessor of `N_CPU` processors. Every interrupt line owns a routing entry: a processor mask and a mode flag. In fixed mode the request goes to the processor named by the lowest set bit of the mask. In redirectable mode the router reads a two-bit load hint that each processor keeps up to date and sends the request to the least busy processor. The scan for the least busy processor starts at the entry's default processor, so that processor wins any tie.

Requests arrive as a strobe with an interrupt number. The result appears one cycle later as a one-hot destination vector and a binary processor index. A configuration port writes routing entries. A per-processor write port updates the hints. A global enable input says whether the platform supports redirection at all. When it is low, every entry is delivered in fixed mode.

Top module: `irq_dest_router`

## Requirements
- R1: Every result names exactly one processor: `dst_onehot` has a single bit set, at position `dst_idx`.
- R2: An entry with `cfg_redir`=0 delivers to the processor given by the lowest-numbered set bit of its mask, and any higher set bits have no effect.
- R3: An entry with `cfg_redir`=1, while `redir_en` is high, delivers to a processor whose hint holds the smallest value among all processors.
- R4: The redirectable search visits the default processor (the lowest set mask bit) first, then default+1 and upward, wrapping modulo `N_CPU`. On equal hints the first processor visited wins.
- R5: Hints are 2 bits: 00 idle, 01 busy, 11 going offline. A processor at 11 is chosen only when every processor is at 11, and in that case the default processor is chosen.
- R6: After reset every entry has mask 1 (processor 0) and mode redirectable, every hint is 00, all outputs are 0 and `cfg_err` is 0.
- R7: While `redir_en` is low, every entry is delivered in fixed mode, whatever its mode flag says.
- R8: An entry whose mask is all zeros delivers to processor 0 in either mode. It also sets `cfg_err`, which stays high until reset.
- R9: `dst_valid` is high exactly in the cycle after a cycle with `req_valid` high. `dst_onehot` and `dst_idx` hold their values between requests.
- R10: A hint write or routing-entry write in the same cycle as a request does not affect that request. It takes effect from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_en | input | 1 | Platform supports redirectable delivery |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_irq | input | IRQ_W | Entry to write |
| cfg_mask | input | N_CPU | Processor mask for the entry |
| cfg_redir | input | 1 | 1 = redirectable, 0 = fixed |
| hint_we | input | N_CPU | Per-processor hint write strobe |
| hint_wdata | input | 2*N_CPU | Hint values, processor i in bits [2i+1:2i] |
| req_valid | input | 1 | Interrupt request strobe |
| req_irq | input | IRQ_W | Requesting interrupt line |
| dst_valid | output | 1 | Result valid, one cycle after request |
| dst_onehot | output | N_CPU | One-hot destination |
| dst_idx | output | CPU_W | Destination processor index |
| cfg_err | output | 1 | Sticky: a request hit an all-zero mask |

## Verification
The bench targets ties between equal hints, where a design that searches from processor 0 instead of from the default would pick a lower-numbered processor. It also targets searches that must wrap past the top processor, where a design without wrap-around would miss a processor. It covers the all-offline case, a mask with several bits set, and the all-zero mask with its sticky flag. It drives hint and entry writes in the same cycle as a request. A design that forwarded the new value would choose a different processor on that request. It also checks that clearing `redir_en` forces fixed delivery even for redirectable entries.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int HINT_W = 2;
  localparam logic [HINT_W-1:0] HINT_IDLE    = 2'b00;
  localparam logic [HINT_W-1:0] HINT_BUSY    = 2'b01;
  localparam logic [HINT_W-1:0] HINT_OFFLINE = 2'b11;
endpackage

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int N_CPU = 8,
  parameter int N_IRQ = 16,
  localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IRQ_W-1:0] waddr,
  input  logic [N_CPU-1:0] wmask,
  input  logic             wredir,
  input  logic [IRQ_W-1:0] raddr,
  output logic [N_CPU-1:0] rmask,
  output logic             rredir
);
  // Storage has no reset so it maps to distributed RAM; a per-entry
  // written flag supplies the reset contents instead.
  logic [N_CPU-1:0] mask_mem  [N_IRQ];
  logic             redir_mem [N_IRQ];
  logic [N_IRQ-1:0] written;

  always_ff @(posedge clk) begin
    if (we) begin
      mask_mem[waddr]  <= wmask;
      redir_mem[waddr] <= wredir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[waddr] <= 1'b1;
  end

  always_comb begin
    if (written[raddr]) begin
      rmask  = mask_mem[raddr];
      rredir = redir_mem[raddr];
    end else begin
      rmask  = {{(N_CPU-1){1'b0}}, 1'b1};
      rredir = 1'b1;
    end
  end
endmodule

// File: rtl/irq_hint_regs.sv
module irq_hint_regs
  import irq_rt_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_CPU-1:0]               we,
  input  logic [N_CPU*HINT_W-1:0]        wdata,
  output logic [N_CPU-1:0][HINT_W-1:0]   hints
);
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst)        hints[i] <= HINT_IDLE;
      else if (we[i]) hints[i] <= wdata[HINT_W*i +: HINT_W];
    end
  end
endmodule

// File: rtl/irq_lowest_scan.sv
module irq_lowest_scan
  import irq_rt_pkg::*;
#(
  parameter int N_CPU = 8,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CPU-1:0][HINT_W-1:0] hints,
  input  logic [CPU_W-1:0]             start,
  output logic [CPU_W-1:0]             sel
);
  logic [HINT_W-1:0] best_val;

  always_comb begin
    int c;
    best_val = hints[start];
    sel      = start;
    for (int k = 1; k < N_CPU; k++) begin
      c = int'(start) + k;
      if (c >= N_CPU) c = c - N_CPU;
      if (hints[c] < best_val) begin
        best_val = hints[c];
        sel      = CPU_W'(c);
      end
    end
  end

  // R3: the selected processor is never busier than any other
  for (genvar i = 0; i < N_CPU; i++) begin : g_chk
    assert_min_hint_R3: assert property (@(posedge clk) disable iff (rst)
      hints[sel] <= hints[i]);
  end
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_rt_pkg::*;
#(
  parameter int N_CPU = 8,
  parameter int N_IRQ = 16,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      redir_en,
  input  logic                      cfg_we,
  input  logic [IRQ_W-1:0]          cfg_irq,
  input  logic [N_CPU-1:0]          cfg_mask,
  input  logic                      cfg_redir,
  input  logic [N_CPU-1:0]          hint_we,
  input  logic [N_CPU*HINT_W-1:0]   hint_wdata,
  input  logic                      req_valid,
  input  logic [IRQ_W-1:0]          req_irq,
  output logic                      dst_valid,
  output logic [N_CPU-1:0]          dst_onehot,
  output logic [CPU_W-1:0]          dst_idx,
  output logic                      cfg_err
);
  logic [N_CPU-1:0]               ent_mask;
  logic                           ent_redir;
  logic [N_CPU-1:0][HINT_W-1:0]   hints;
  logic [CPU_W-1:0]               dflt_cpu;
  logic [CPU_W-1:0]               scan_cpu;
  logic [CPU_W-1:0]               pick;
  logic                           mask_zero;
  logic                           use_redir;

  irq_route_table #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) u_table (
    .clk(clk), .rst(rst),
    .we(cfg_we), .waddr(cfg_irq), .wmask(cfg_mask), .wredir(cfg_redir),
    .raddr(req_irq), .rmask(ent_mask), .rredir(ent_redir)
  );

  irq_hint_regs #(.N_CPU(N_CPU)) u_hints (
    .clk(clk), .rst(rst), .we(hint_we), .wdata(hint_wdata), .hints(hints)
  );

  irq_lowest_scan #(.N_CPU(N_CPU)) u_scan (
    .clk(clk), .rst(rst), .hints(hints), .start(dflt_cpu), .sel(scan_cpu)
  );

  // lowest set bit of the mask is the default processor
  always_comb begin
    dflt_cpu = '0;
    for (int i = N_CPU - 1; i >= 0; i--)
      if (ent_mask[i]) dflt_cpu = CPU_W'(i);
  end

  assign mask_zero = (ent_mask == '0);
  assign use_redir = redir_en & ent_redir & ~mask_zero;
  assign pick      = use_redir ? scan_cpu : dflt_cpu;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_valid  <= 1'b0;
      dst_onehot <= '0;
      dst_idx    <= '0;
      cfg_err    <= 1'b0;
    end else begin
      dst_valid <= req_valid;
      if (req_valid) begin
        dst_idx    <= pick;
        dst_onehot <= {{(N_CPU-1){1'b0}}, 1'b1} << pick;
        if (mask_zero) cfg_err <= 1'b1;
      end
    end
  end

  assert_single_dest_R1: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> $countones(dst_onehot) == 1);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> $past(req_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(dst_idx) && $stable(dst_onehot));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mask_zero) |=> (dst_idx == '0) && cfg_err);
endmodule

// File: tb/tb_irq_dest_router.sv
`timescale 1ns/1ps
module tb_irq_dest_router;
  localparam int N = 8;
  localparam int NI = 16;
  localparam int CW = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic redir_en = 1'b1;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_irq = '0;
  logic [N-1:0] cfg_mask = '0;
  logic cfg_redir = 1'b0;
  logic [N-1:0] hint_we = '0;
  logic [2*N-1:0] hint_wdata = '0;
  logic req_valid = 1'b0;
  logic [IW-1:0] req_irq = '0;
  logic dst_valid;
  logic [N-1:0] dst_onehot;
  logic [CW-1:0] dst_idx;
  logic cfg_err;

  always #2.5 clk = ~clk;

  irq_dest_router #(.N_CPU(N), .N_IRQ(NI)) dut (
    .clk(clk), .rst(rst), .redir_en(redir_en),
    .cfg_we(cfg_we), .cfg_irq(cfg_irq), .cfg_mask(cfg_mask), .cfg_redir(cfg_redir),
    .hint_we(hint_we), .hint_wdata(hint_wdata),
    .req_valid(req_valid), .req_irq(req_irq),
    .dst_valid(dst_valid), .dst_onehot(dst_onehot), .dst_idx(dst_idx),
    .cfg_err(cfg_err)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  logic [N-1:0] m_mask [NI];
  logic         m_redir [NI];
  logic [1:0]   m_hint [N];
  logic         m_err;

  int     exp_q [$];
  logic   err_q [$];
  string  tag_q [$];

  function automatic int expect_cpu(int irq);
    int d, minv;
    if (m_mask[irq] == '0) return 0;
    d = 0;
    while (!m_mask[irq][d]) d++;
    if (!(redir_en && m_redir[irq])) return d;
    minv = 3;
    for (int i = 0; i < N; i++) if (int'(m_hint[i]) < minv) minv = int'(m_hint[i]);
    for (int k = 0; k < N; k++) if (int'(m_hint[(d + k) % N]) == minv) return (d + k) % N;
    return d;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one-cycle drive: request plus optional same-cycle hint and entry writes
  task automatic drive(bit rq, int irq, logic [N-1:0] hwe, logic [2*N-1:0] hwd,
                       bit cwe, int cirq, logic [N-1:0] cm, bit cr, string tag);
    @(negedge clk);
    req_valid = rq; req_irq = IW'(irq);
    hint_we = hwe; hint_wdata = hwd;
    cfg_we = cwe; cfg_irq = IW'(cirq); cfg_mask = cm; cfg_redir = cr;
    if (rq) begin
      exp_q.push_back(expect_cpu(irq));
      if (m_mask[irq] == '0) m_err = 1'b1;
      err_q.push_back(m_err);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < N; i++) if (hwe[i]) m_hint[i] = hwd[2*i +: 2];
    if (cwe) begin m_mask[cirq] = cm; m_redir[cirq] = cr; end
    @(negedge clk);
    req_valid = 1'b0; hint_we = '0; cfg_we = 1'b0;
  endtask

  task automatic req(int irq, string tag);
    drive(1, irq, '0, '0, 0, 0, '0, 0, tag);
  endtask

  task automatic cfg(int irq, logic [N-1:0] m, bit r);
    drive(0, 0, '0, '0, 1, irq, m, r, "cfg");
  endtask

  task automatic set_hints(logic [2*N-1:0] v);
    drive(0, 0, '1, v, 0, 0, '0, 0, "hint");
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && dst_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected dst_valid", 1, 0);
      end else begin
        int e; logic er; string t;
        e = exp_q.pop_front(); er = err_q.pop_front(); t = tag_q.pop_front();
        check(int'(dst_idx) == e, t, "dst_idx", int'(dst_idx), e);
        check(dst_onehot == (N'(1) << e), "R1", "dst_onehot", int'(dst_onehot), 1 << e);
        check(cfg_err == er, t, "cfg_err", int'(cfg_err), int'(er));
      end
    end
  end

  function automatic logic [2*N-1:0] pack(logic [1:0] h7, logic [1:0] h6, logic [1:0] h5,
      logic [1:0] h4, logic [1:0] h3, logic [1:0] h2, logic [1:0] h1, logic [1:0] h0);
    return {h7, h6, h5, h4, h3, h2, h1, h0};
  endfunction

  initial begin
    #750000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NI; i++) begin m_mask[i] = 8'h01; m_redir[i] = 1'b1; end
    for (int i = 0; i < N; i++) m_hint[i] = 2'b00;
    m_err = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R6: reset state at the ports
    check(dst_valid == 0 && dst_onehot == 0 && dst_idx == 0, "R6", "outputs after reset",
          int'(dst_onehot), 0);
    check(cfg_err == 0, "R6", "cfg_err after reset", int'(cfg_err), 0);
    req(3, "R6");                                  // default entry -> CPU 0
    // make CPU 0 busy: a default redirectable entry must move off CPU 0
    set_hints(pack(2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 2'b01, 2'b01));
    req(4, "R6");                                  // -> CPU 3
    // R2: fixed, several bits set
    cfg(5, 8'b1010_1000, 0);
    req(5, "R2");                                  // -> 3
    // R4 tie with wrap: default 5, idle at 2 and 7 -> 7
    cfg(6, 8'b0010_0000, 1);
    set_hints(pack(2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 2'b01));
    req(6, "R4");
    // R3 wrap: only CPU 1 idle
    set_hints(pack(2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b11));
    req(6, "R3");
    // R4 default preferred on tie
    set_hints(pack(2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01));
    req(6, "R4");
    // R5: offline avoided, all offline -> default
    set_hints(pack(2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b11));
    req(6, "R5");                                  // -> 1
    set_hints('1);
    req(6, "R5");                                  // -> 5
    // R7: capability off forces fixed
    set_hints(pack(2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    redir_en = 1'b0;
    req(6, "R7");                                  // -> 5 despite offline hint
    redir_en = 1'b1;
    req(6, "R7");                                  // back to redirectable -> 6
    // R10: same-cycle hint write not seen
    set_hints(pack(2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01));
    drive(1, 6, 8'b0010_0000, pack(2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00),
          0, 0, '0, 0, "R10");                     // -> 5 (old)
    req(6, "R10");                                 // -> 6
    // R10: same-cycle entry write not seen
    drive(1, 5, '0, '0, 1, 5, 8'b0000_0100, 0, "R10");  // -> 3 (old)
    req(5, "R10");                                 // -> 2
    // R8: zero mask -> CPU 0, sticky flag
    cfg(9, 8'h00, 1);
    set_hints(pack(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11));
    req(9, "R8");
    req(5, "R8");                                  // flag stays high
    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      logic [2*N-1:0] hv;
      for (int i = 0; i < N; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hv[2*i +: 2] = (lfsr[1:0] == 2'b10) ? 2'b11 : lfsr[1:0];
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      redir_en = (lfsr[3:0] != 4'h0);
      drive(1, int'(lfsr[7:4]), lfsr[15:8], hv, lfsr[2], int'(lfsr[11:8]),
            (lfsr[14:12] == 3'b000) ? 8'h00 : lfsr[15:8] ^ hv[7:0], lfsr[1], "R3");
    end
    redir_en = 1'b1;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "missing results", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule